// File: doc/BRIEF.md
# Serial Peripheral Master with Frame Select

This block is the master end of a four-wire synchronous serial link. Software-side logic pushes words into a small transmit queue. The block then shifts each word out most significant bit first on the data output. At the same time it drives the serial clock and an active-low frame select, and it samples the data input. Each received word is placed right-aligned into a receive queue, which the surrounding logic pops at its own pace.

Four settings are taken when a frame begins and held until that frame ends: clock idle level, clock phase, word size (4 to 16 bits) and clock divider. One half period of the serial clock lasts half the divider value in system clocks. Words that are queued while a frame is running follow on without a break: frame select stays low and the clock keeps its rhythm. The frame closes only when the transmit queue has run dry or the block has been disabled.

Top module: `spi_frame_master`

## Requirements
- R1: While no frame is active, `fss_n` is 1, `mosi` is 0 and `sclk` equals `cpol`.
- R2: A frame begins (fall of `fss_n`) only when `enable` and `master_en` are both 1 and the transmit queue holds a word. With either control at 0, queued words stay put and `fss_n` stays high.
- R3: `word_len` holds the word size minus one (3 to 15, values below 3 act as 3). Exactly that many bits are sent per word, most significant first. Bits of `tx_data` above the word size are ignored.
- R4: A half period of `sclk` lasts `clk_div/2` system clocks (minimum 1). The first `sclk` edge comes exactly one half period after `fss_n` falls.
- R5: With `cpha`=1, each bit is launched on the first clock edge of its pair and captured on the second. With `cpha`=0, the first bit is on `mosi` from the fall of `fss_n`, bits are captured on the first edge of each pair, and the next bit is launched on the second edge.
- R6: `fss_n` rises exactly two half periods after the last capture edge of the final word, and `sclk` is already back at its idle level when it does.
- R7: Words queued before a word ends are sent in the same frame. `fss_n` stays low between them and the clock runs without a gap.
- R8: Each received word appears on `rx_data` right-aligned, with every bit above the word size at 0.
- R9: A word completed while the receive queue is full is dropped, and `overrun` goes to 1 and stays there until reset.
- R10: `sclk_oe` is 1 only while `master_en` is 1.
- R11: `busy` is 1 exactly while `fss_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows new frames and word continuation |
| master_en | input | 1 | Master role; enables the clock pad and frames |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 capture on first edge, 1 launch on first edge |
| word_len | input | 4 | Word size minus one |
| clk_div | input | 8 | Even system-clock divider for the serial clock |
| tx_data | input | 16 | Word to queue for sending |
| tx_push | input | 1 | Queue `tx_data` (ignored when full) |
| tx_full | output | 1 | Transmit queue is full |
| rx_data | output | 16 | Oldest received word |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_empty | output | 1 | Receive queue is empty |
| miso | input | 1 | Serial data input |
| sclk | output | 1 | Serial clock |
| sclk_oe | output | 1 | Output enable for the serial clock pad |
| fss_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data output |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | Sticky flag for a dropped received word |

## Verification
Some rules are checked on every cycle by the assertions. The data output must be low whenever frame select is high. A frame may open only while both controls allow it. The clock must already be at its idle level when frame select rises. The busy flag must track frame select, and the overrun flag must never clear. Other behaviour can only be shown by the bench's scenarios, where a slave model shifts data both ways and measures timing in system clocks. This covers bit order and word size, the edge on which each phase captures and launches, the lead and tail delays, several words sharing one frame, right alignment of received words, and which word is lost on overflow.

// File: rtl/spi_fm_pkg.sv
// Shared definitions for the serial master: the sequencer state encoding.
package spi_fm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } spi_state_t;
endpackage

// File: rtl/spi_fm_fifo.sv
// Synchronous first-in first-out queue with show-ahead read data.
// Assumes DEPTH is a power of two of at least 2. A push into a full queue
// and a pop from an empty queue are ignored.
module spi_fm_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wptr;
    logic [AW:0]  rptr;
    logic         do_push;
    logic         do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (wptr == rptr);
    assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign rdata   = mem[rptr[AW-1:0]];

    // Advance the pointers on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
        end
    end

    // Store an accepted word in the slot the write pointer names.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr[AW-1:0]] <= wdata;
    end
endmodule

// File: rtl/spi_fm_halfclk.sv
// Half-period tick generator. While run is high it pulses tick once every
// div/2 system clocks (at least every clock). The count restarts from zero
// whenever run is low, so the first tick comes a full half period after run
// rises.
module spi_fm_halfclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] hcnt;

    // Half period in system clocks, floored at one.
    always_comb begin
        half = div >> 1;
        if (half == '0) half = {{(DIV_W-1){1'b0}}, 1'b1};
    end

    assign tick = run && (hcnt == half - 1'b1);

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)      hcnt <= '0;
        else if (!run)   hcnt <= '0;
        else if (tick)   hcnt <= '0;
        else             hcnt <= hcnt + 1'b1;
    end
endmodule

// File: rtl/spi_fm_engine.sv
// Frame sequencer and shift datapath. Opens a frame when allowed and a word
// is waiting, waits a half period, then toggles the clock on each tick,
// capturing and launching according to the latched phase. Words continue
// back to back while data is queued; the frame closes two half periods after
// the last capture. Assumes the transmit queue read data is show-ahead and
// that configuration inputs are sampled only at frame start.
module spi_fm_engine
    import spi_fm_pkg::*;
#(
    parameter int MAXB  = 16,
    parameter int DIV_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     master_en,
    input  logic                     cpol,
    input  logic                     cpha,
    input  logic [$clog2(MAXB)-1:0]  word_len,
    input  logic [DIV_W-1:0]         clk_div,
    input  logic                     tx_empty,
    input  logic [MAXB-1:0]          tx_word,
    output logic                     tx_pop,
    input  logic                     rx_full,
    output logic                     rx_push,
    output logic [MAXB-1:0]          rx_word,
    input  logic                     miso,
    output logic                     sclk,
    output logic                     fss_n,
    output logic                     mosi,
    output logic                     busy,
    output logic                     overrun
);
    localparam int LW  = $clog2(MAXB);
    localparam int ECW = LW + 1;
    localparam logic [LW-1:0] MIN_LEN = LW'(3);
    localparam logic [LW-1:0] TOP_BIT = LW'(MAXB - 1);

    spi_state_t       state;
    logic             fss_q;
    logic             sclk_q;
    logic             mosi_q;
    logic             cpol_q;
    logic             cpha_q;
    logic [LW-1:0]    len_q;
    logic [DIV_W-1:0] div_q;
    logic [MAXB-1:0]  shreg;
    logic [MAXB-1:0]  rxsh;
    logic [ECW-1:0]   ecnt;
    logic [1:0]       tcnt;
    logic             ovr_q;

    logic             tick;
    logic             run;
    logic             start;
    logic             cont;
    logic             edge_now;
    logic             at_last;
    logic             is_cap;
    logic             is_launch;
    logic [LW-1:0]    eff_len;
    logic [LW-1:0]    load_len;
    logic             load_pha;
    logic [MAXB-1:0]  aligned;

    assign run = (state != ST_IDLE);

    spi_fm_halfclk #(.DIV_W(DIV_W)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_q),
        .tick  (tick)
    );

    // Word size field clamped to the smallest legal size.
    assign eff_len = (word_len < MIN_LEN) ? MIN_LEN : word_len;

    // Frame opening and word continuation conditions.
    assign start    = (state == ST_IDLE) && enable && master_en && !tx_empty;
    assign cont     = enable && master_en && !tx_empty;
    assign edge_now = tick && ((state == ST_LEAD) || (state == ST_SHIFT));
    assign at_last  = (ecnt == {len_q, 1'b1});

    // Edge roles: pair position decides capture versus launch per phase.
    assign is_cap    = cpha_q ? ecnt[0] : ~ecnt[0];
    assign is_launch = cpha_q ? ~ecnt[0] : (ecnt[0] && !at_last);

    // Left-align the queued word so its top bit sits in the shift MSB.
    assign load_len = (state == ST_IDLE) ? eff_len : len_q;
    assign load_pha = (state == ST_IDLE) ? cpha : cpha_q;
    assign aligned  = tx_word << (TOP_BIT - load_len);

    assign tx_pop  = start || (edge_now && at_last && cont);
    assign rx_word = cpha_q ? {rxsh[MAXB-2:0], miso} : rxsh;
    assign rx_push = edge_now && at_last && !rx_full;

    assign sclk    = (state == ST_IDLE) ? cpol : sclk_q;
    assign fss_n   = fss_q;
    assign mosi    = mosi_q;
    assign busy    = run;
    assign overrun = ovr_q;

    // Sequencer: frame open, lead, edge stepping, word chaining and tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            fss_q  <= 1'b1;
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            len_q  <= MIN_LEN;
            div_q  <= '0;
            shreg  <= '0;
            rxsh   <= '0;
            ecnt   <= '0;
            tcnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_LEAD;
                        fss_q  <= 1'b0;
                        cpol_q <= cpol;
                        cpha_q <= cpha;
                        len_q  <= eff_len;
                        div_q  <= clk_div;
                        sclk_q <= cpol;
                        ecnt   <= '0;
                        rxsh   <= '0;
                        if (load_pha) begin
                            shreg <= aligned;
                        end else begin
                            mosi_q <= aligned[MAXB-1];
                            shreg  <= aligned << 1;
                        end
                    end
                end
                ST_LEAD, ST_SHIFT: begin
                    if (edge_now) begin
                        sclk_q <= ~sclk_q;
                        if (is_cap) rxsh <= {rxsh[MAXB-2:0], miso};
                        if (is_launch) begin
                            mosi_q <= shreg[MAXB-1];
                            shreg  <= shreg << 1;
                        end
                        if (at_last) begin
                            if (cont) begin
                                state <= ST_SHIFT;
                                ecnt  <= '0;
                                rxsh  <= '0;
                                if (load_pha) begin
                                    shreg <= aligned;
                                end else begin
                                    mosi_q <= aligned[MAXB-1];
                                    shreg  <= aligned << 1;
                                end
                            end else begin
                                state <= ST_TAIL;
                                tcnt  <= cpha_q ? 2'd2 : 2'd1;
                            end
                        end else begin
                            state <= ST_SHIFT;
                            ecnt  <= ecnt + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        if (tcnt == 2'd1) begin
                            state  <= ST_IDLE;
                            fss_q  <= 1'b1;
                            mosi_q <= 1'b0;
                        end else begin
                            tcnt <= tcnt - 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sticky overrun: a finished word met a full receive queue.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ovr_q <= 1'b0;
        else if (edge_now && at_last && rx_full) ovr_q <= 1'b1;
    end
endmodule

// File: rtl/spi_frame_master.sv
// Top of the serial master: transmit queue, receive queue and the frame
// sequencer. The clock pad enable follows the master role input. Assumes
// clk_div is even and configuration is stable while a frame runs.
module spi_frame_master #(
    parameter int MAXB     = 16,
    parameter int DIV_W    = 8,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    master_en,
    input  logic                    cpol,
    input  logic                    cpha,
    input  logic [$clog2(MAXB)-1:0] word_len,
    input  logic [DIV_W-1:0]        clk_div,
    input  logic [MAXB-1:0]         tx_data,
    input  logic                    tx_push,
    output logic                    tx_full,
    output logic [MAXB-1:0]         rx_data,
    input  logic                    rx_pop,
    output logic                    rx_empty,
    input  logic                    miso,
    output logic                    sclk,
    output logic                    sclk_oe,
    output logic                    fss_n,
    output logic                    mosi,
    output logic                    busy,
    output logic                    overrun
);
    logic            tx_empty;
    logic [MAXB-1:0] tx_word;
    logic            tx_pop;
    logic            rx_full;
    logic            rx_push;
    logic [MAXB-1:0] rx_word;

    spi_fm_fifo #(.W(MAXB), .DEPTH(TX_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (tx_data),
        .pop   (tx_pop),
        .rdata (tx_word),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_fm_fifo #(.W(MAXB), .DEPTH(RX_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_pop),
        .rdata (rx_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_fm_engine #(.MAXB(MAXB), .DIV_W(DIV_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .master_en (master_en),
        .cpol      (cpol),
        .cpha      (cpha),
        .word_len  (word_len),
        .clk_div   (clk_div),
        .tx_empty  (tx_empty),
        .tx_word   (tx_word),
        .tx_pop    (tx_pop),
        .rx_full   (rx_full),
        .rx_push   (rx_push),
        .rx_word   (rx_word),
        .miso      (miso),
        .sclk      (sclk),
        .fss_n     (fss_n),
        .mosi      (mosi),
        .busy      (busy),
        .overrun   (overrun)
    );

    // Clock pad is driven only in the master role.
    assign sclk_oe = master_en;
endmodule

// File: rtl/spi_frame_master_chk.sv
// Cycle-level rules for the serial master, attached by bind.
module spi_frame_master_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic master_en,
    input logic cpol,
    input logic sclk,
    input logic fss_n,
    input logic mosi,
    input logic busy,
    input logic overrun
);
    // R1
    idle_data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fss_n |-> (mosi == 1'b0));

    // R2
    frame_open_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fss_n) |-> $past(enable && master_en));

    // R6
    release_at_idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fss_n) |-> ($past(sclk) == cpol));

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R11
    busy_tracks_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !fss_n);
endmodule

bind spi_frame_master spi_frame_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .master_en (master_en),
    .cpol      (cpol),
    .sclk      (sclk),
    .fss_n     (fss_n),
    .mosi      (mosi),
    .busy      (busy),
    .overrun   (overrun)
);

// File: tb/spi_frame_master_test.sv
module spi_frame_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        master_en = 1'b1;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic [3:0]  word_len = 4'd7;
    logic [7:0]  clk_div = 8'd2;
    logic [15:0] tx_data = '0;
    logic        tx_push = 1'b0;
    logic        tx_full;
    logic [15:0] rx_data;
    logic        rx_pop = 1'b0;
    logic        rx_empty;
    logic        miso = 1'b0;
    logic        sclk;
    logic        sclk_oe;
    logic        fss_n;
    logic        mosi;
    logic        busy;
    logic        overrun;

    spi_frame_master uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master_en(master_en),
        .cpol(cpol), .cpha(cpha), .word_len(word_len), .clk_div(clk_div),
        .tx_data(tx_data), .tx_push(tx_push), .tx_full(tx_full),
        .rx_data(rx_data), .rx_pop(rx_pop), .rx_empty(rx_empty),
        .miso(miso), .sclk(sclk), .sclk_oe(sclk_oe), .fss_n(fss_n),
        .mosi(mosi), .busy(busy), .overrun(overrun)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Slave model and monitor state
    int        cyc = 0;
    logic      prev_fss = 1'b1;
    logic      prev_sclk = 1'b0;
    int        en_cnt, bit_cnt, gn, frames_done;
    int        fall_cyc, last_cap, lead_meas, tail_meas;
    bit        first_seen;
    logic [15:0] mon_word, cur_s;
    logic [15:0] slv [64];
    logic [15:0] txw [64];
    logic [15:0] got [64];
    logic [15:0] exp_rx [64];
    int        nbits;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mask_w(input logic [15:0] v, input int n);
        return v & 16'((32'h1 << n) - 1);
    endfunction

    function automatic int half_of(input int dv);
        return (dv / 2 < 1) ? 1 : dv / 2;
    endfunction

    // Sample at the falling clock edge: slave drives miso, monitor records mosi.
    always @(negedge clk) begin
        cyc++;
        nbits = int'(word_len) + 1;
        if (!rst_n) begin
            prev_fss  = 1'b1;
            prev_sclk = sclk;
        end else begin
            if (prev_fss && !fss_n) begin
                fall_cyc   = cyc;
                first_seen = 0;
                en_cnt     = 0;
                bit_cnt    = 0;
                mon_word   = '0;
                cur_s      = slv[gn];
                if (!cpha) miso <= cur_s[nbits-1];
            end else if (!prev_fss && fss_n) begin
                tail_meas = cyc - last_cap;
                frames_done++;
            end else if (!fss_n && sclk != prev_sclk) begin
                if (!first_seen) begin
                    lead_meas  = cyc - fall_cyc;
                    first_seen = 1;
                end
                en_cnt++;
                if (((en_cnt % 2) == 1) != cpha) begin
                    mon_word = {mon_word[14:0], mosi};
                    bit_cnt++;
                    last_cap = cyc;
                    if (bit_cnt == nbits) begin
                        got[gn] = mon_word;
                        gn++;
                        mon_word = '0;
                        bit_cnt  = 0;
                    end
                end else if (cpha) begin
                    miso <= cur_s[nbits - 1 - (en_cnt - 1) / 2];
                end else if (en_cnt < 2 * nbits) begin
                    miso <= cur_s[nbits - 1 - en_cnt / 2];
                end
                if (en_cnt == 2 * nbits) begin
                    en_cnt = 0;
                    cur_s  = slv[gn];
                    if (!cpha) miso <= cur_s[nbits-1];
                end
            end
            prev_fss  = fss_n;
            prev_sclk = sclk;
        end
    end

    task automatic push_word(input logic [15:0] w);
        @(negedge clk);
        tx_data = w;
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_word;
        @(negedge clk);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic wait_frame_end;
        for (int i = 0; i < 20000 && !busy; i++) @(negedge clk);
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // One burst: queue cnt words while disabled, then run them as one frame.
    task automatic burst(input int pol, input int pha, input int wl, input int dv,
                         input int cnt, input bit drain);
        int n;
        int h;
        n = wl + 1;
        h = half_of(dv);
        enable    = 1'b0;
        cpol      = pol[0];
        cpha      = pha[0];
        word_len  = wl[3:0];
        clk_div   = dv[7:0];
        gn        = 0;
        frames_done = 0;
        for (int k = 0; k < 64; k++) slv[k] = 16'($urandom);
        for (int k = 0; k < cnt; k++) begin
            txw[k]    = 16'($urandom);
            exp_rx[k] = mask_w(slv[k], n);
            push_word(txw[k]);
        end
        @(negedge clk);
        enable = 1'b1;
        wait_frame_end();
        enable = 1'b0;
        chk(gn == cnt, "R3 word count", gn, cnt);
        for (int k = 0; k < cnt && k < gn; k++)
            chk(got[k] == mask_w(txw[k], n), "R3/R5 mosi word", got[k], mask_w(txw[k], n));
        // R7 all words in a single frame
        chk(frames_done == 1, "R7 frames per burst", frames_done, 1);
        chk(lead_meas == h, "R4 lead delay", lead_meas, h);
        chk(tail_meas == 2 * h, "R6 tail delay", tail_meas, 2 * h);
        chk(fss_n == 1'b1 && mosi == 1'b0 && sclk == pol[0], "R1 idle levels",
            {fss_n, mosi, sclk}, {1'b1, 1'b0, pol[0]});
        if (drain) begin
            for (int k = 0; k < cnt; k++) begin
                chk(!rx_empty, "R8 rx present", rx_empty, 0);
                chk(rx_data == exp_rx[k], "R8/R5 rx word", rx_data, exp_rx[k]);
                pop_word();
            end
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fss_n == 1'b1, "R1 reset fss_n", fss_n, 1);
        chk(mosi == 1'b0, "R1 reset mosi", mosi, 0);
        chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
        chk(busy == 1'b0, "R11 reset busy", busy, 0);
        chk(rx_empty == 1'b1, "R8 reset rx_empty", rx_empty, 1);
        chk(overrun == 1'b0, "R9 reset overrun", overrun, 0);

        // Directed: phase 1 polarity 0, two words back to back
        burst(0, 1, 7, 2, 2, 1);
        // Directed: smallest word, polarity 1 phase 0
        burst(1, 0, 3, 4, 1, 1);
        // Directed: largest word, full queue, slow clock
        burst(1, 1, 15, 6, 4, 1);
        // Directed: phase 0 polarity 0, three words
        burst(0, 0, 11, 2, 3, 1);

        // R2 and R10: queued word held while disabled or not master
        for (int k = 0; k < 64; k++) slv[k] = 16'($urandom);
        gn = 0; frames_done = 0;
        cpol = 1'b0; cpha = 1'b0; word_len = 4'd7; clk_div = 8'd2;
        push_word(16'h00A5);
        repeat (40) @(negedge clk);
        chk(fss_n == 1'b1 && busy == 1'b0, "R2 no start when disabled", fss_n, 1);
        master_en = 1'b0;
        enable    = 1'b1;
        repeat (40) @(negedge clk);
        chk(fss_n == 1'b1, "R2 no start without master role", fss_n, 1);
        chk(sclk_oe == 1'b0, "R10 pad off without master role", sclk_oe, 0);
        master_en = 1'b1;
        @(negedge clk);
        chk(sclk_oe == 1'b1, "R10 pad on in master role", sclk_oe, 1);
        wait_frame_end();
        enable = 1'b0;
        chk(gn == 1 && got[0] == 16'h00A5, "R2 word sent once allowed", got[0], 16'h00A5);
        chk(rx_data == mask_w(slv[0], 8), "R8 rx after release", rx_data, mask_w(slv[0], 8));
        pop_word();

        // R9: fill the receive queue, then overflow it
        burst(0, 1, 7, 2, 4, 0);
        chk(overrun == 1'b0, "R9 no overrun at exactly full", overrun, 0);
        begin
            logic [15:0] keep [4];
            for (int k = 0; k < 4; k++) keep[k] = exp_rx[k];
            burst(0, 1, 7, 2, 2, 0);
            chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
            for (int k = 0; k < 4; k++) begin
                chk(rx_data == keep[k], "R9 oldest words kept", rx_data, keep[k]);
                pop_word();
            end
            chk(rx_empty == 1'b1, "R9 newer words dropped", rx_empty, 1);
            repeat (5) @(negedge clk);
            chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
        end

        // R3: upper tx bits beyond word size are ignored
        burst(0, 0, 4, 2, 1, 1);

        // Constrained random bursts
        for (int r = 0; r < 12; r++) begin
            int pol, pha, wl, dv, cnt;
            pol = int'($urandom % 2);
            pha = int'($urandom % 2);
            wl  = 3 + int'($urandom % 13);
            dv  = 2 * (1 + int'($urandom % 3));
            cnt = 1 + int'($urandom % 4);
            burst(pol, pha, wl, dv, cnt, 1);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'd20240611);
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule